// File: doc/BRIEF.md
# Free-Running Sync Tick Counter

This peripheral counts pulses of a slow reference tick (nominally 32768 per second, delivered as a one-cycle enable that is synchronous to the bus clock) and presents the running count, together with a constant identification value, on a small read-only register bus. Software reads the count as one 32-bit word. A bus that can only do half-word transfers reads the low half first. The block then freezes the upper half in a holding register, so that the following high-half read yields an upper half consistent with the low half already taken.

Writes never change anything. Illegal accesses produce a one-cycle error pulse that software or a bus fabric can turn into a fault. An access is illegal if it is a byte transfer, uses the reserved size code, or targets an unmapped location. All write transfers are flagged too. Each read returns its data one bus clock after the strobe.

Top module: `sync_tick_counter`

## Requirements
- R1: After reset the count and the holding register are zero, and `rd_valid`, `rd_data`, `err_reg` and `err_width` are all zero.
- R2: A word read (`size` = 2'b10) at offset 0x00 returns 0x0000_0021, with `rd_valid` high in the cycle after the strobe.
- R3: A word read at offset 0x10 returns the number of ticks seen since reset. A tick in the same cycle as the read strobe is not included in the returned value.
- R4: The count is `CNT_W` bits wide and rolls over from all ones to zero with no flag. Narrower counts are zero-extended to 32 bits.
- R5: A half-word read (`size` = 2'b01) with address bit 1 clear returns the low 16 bits of the addressed register, zero-extended. It also loads the upper 16 bits of that register into the holding register.
- R6: A half-word read with address bit 1 set returns the holding register, zero-extended, at any offset. It raises no error and does not sample the live count.
- R7: The holding register is zero after reset and changes only on a half-word read with address bit 1 clear.
- R8: A word read, or a half-word read with address bit 1 clear, at any offset other than 0x00 and 0x10 returns zero and pulses `err_reg`. In the half-word case, zero is loaded into the holding register.
- R9: Writes change neither the count nor the holding register. Word and half-word writes pulse `err_reg` in the cycle after the strobe.
- R10: Byte transfers (`size` = 2'b00) and the reserved size 2'b11 pulse `err_width` in the cycle after the strobe, in either direction. A read of this kind returns zero and leaves the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle reference tick, synchronous to `clk` |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (never together with `rd_en`) |
| size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| addr | input | AW | Byte address within the block |
| wr_data | input | 32 | Write data (ignored) |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High for one cycle after each read strobe |
| err_reg | output | 1 | Bad-register pulse, one cycle after the strobe |
| err_width | output | 1 | Bad-width pulse, one cycle after the strobe |

## Verification
A corrupted count appears at the next word or low-half read as a value off from the tick total, one cycle after the strobe. A wrong holding register appears only at the next high-half read. For this reason the bench lets the live upper half move away from the latched one before it reads the high half back. A byte access or write that disturbs state shows at the next counter or high-half read. The bench also runs a second instance with an 8-bit count through many roll-overs, alongside the 32-bit instance.

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
  parameter int AW    = 8,
  parameter int CNT_W = 32,
  parameter logic [31:0] REV_VAL = 32'h21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic          err_reg,
  output logic          err_width
);
  localparam logic [1:0]    SZ_BYTE = 2'b00;
  localparam logic [1:0]    SZ_HALF = 2'b01;
  localparam logic [1:0]    SZ_WORD = 2'b10;
  localparam logic [1:0]    SZ_RSVD = 2'b11;
  localparam logic [AW-1:0] OFS_REV = AW'(8'h00);
  localparam logic [AW-1:0] OFS_CNT = AW'(8'h10);

  logic [CNT_W-1:0] cnt;
  logic [15:0]      hold;
  logic [31:0]      reg_val, rd_next;
  logic             hit_rev, hit_cnt, bad_size;
  logic             rd_word, rd_lo, rd_hi, rd_bw, wr_bw, wr_bad;

  assign hit_rev  = addr == OFS_REV;
  assign hit_cnt  = addr == OFS_CNT;
  assign reg_val  = hit_rev ? REV_VAL : hit_cnt ? 32'(cnt) : 32'h0;
  assign bad_size = size == SZ_BYTE || size == SZ_RSVD;

  assign rd_word = rd_en && size == SZ_WORD;
  assign rd_lo   = rd_en && size == SZ_HALF && !addr[1];
  assign rd_hi   = rd_en && size == SZ_HALF &&  addr[1];
  assign rd_bw   = rd_en && bad_size;
  assign wr_bw   = wr_en && bad_size;
  assign wr_bad  = wr_en && !bad_size;

  always_comb begin
    rd_next = 32'h0;
    if (rd_word)    rd_next = reg_val;
    else if (rd_lo) rd_next = {16'h0, reg_val[15:0]};
    else if (rd_hi) rd_next = {16'h0, hold};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      hold      <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      err_reg   <= 1'b0;
      err_width <= 1'b0;
    end else begin
      cnt       <= cnt + CNT_W'(tick_en);
      if (rd_lo) hold <= reg_val[31:16];
      if (rd_en) rd_data <= rd_next;
      rd_valid  <= rd_en;
      err_reg   <= ((rd_word || rd_lo) && !(hit_rev || hit_cnt)) || wr_bad;
      err_width <= rd_bw || wr_bw;
    end
  end

  logic unused_wr;
  assign unused_wr = ^wr_data;

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + CNT_W'($past(tick_en)));

  p_valid_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rev_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size == SZ_WORD && addr == OFS_REV) |=> rd_data == 32'h21);

  p_hi_from_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size == SZ_HALF && addr[1]) |=> (rd_data == {16'h0, $past(hold)} && !err_reg));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && size == SZ_HALF && !addr[1]) |=> $stable(hold));

  p_width_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (size == SZ_BYTE || size == SZ_RSVD)) |=> (err_width && rd_data == 32'h0));

  p_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (size == SZ_HALF || size == SZ_WORD)) |=> err_reg);
endmodule

// File: tb/sync_tick_counter_tb_top.sv
module sync_tick_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data, rd_data_s;
  logic        rd_valid, err_reg, err_width, rd_valid_s, err_reg_s, err_width_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tick_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
    .size(size), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .err_reg(err_reg), .err_width(err_width));

  sync_tick_counter #(.CNT_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
    .size(size), .addr(addr), .wr_data(wr_data), .rd_data(rd_data_s),
    .rd_valid(rd_valid_s), .err_reg(err_reg_s), .err_width(err_width_s));

  typedef struct {
    int          due;
    logic        v;
    logic [31:0] d, ds;
    logic        br, bw;
    string       req;
  } item_t;

  item_t       q[$];
  int          cyc = 0, checks = 0, errors = 0;
  logic [31:0] m_cnt = 0;
  logic [15:0] m_hold = 0, m_hold_s = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] regval(input logic [7:0] a, input logic [31:0] c);
    return a == 8'h00 ? 32'h21 : a == 8'h10 ? c : 32'h0;
  endfunction

  task automatic access(input bit rd, input bit wr, input logic [1:0] sz,
                        input logic [7:0] a, input bit tk, input string req);
    item_t it;
    logic [31:0] v, vs;
    @(negedge clk);
    rd_en = rd; wr_en = wr; size = sz; addr = a; tick_en = tk;
    wr_data = 32'hA5A5_0000 ^ m_cnt;
    it.due = cyc + 1; it.v = rd; it.d = 0; it.ds = 0; it.br = 0; it.bw = 0; it.req = req;
    v  = regval(a, m_cnt);
    vs = regval(a, {24'h0, m_cnt[7:0]});
    if (sz == 2'b00 || sz == 2'b11) it.bw = 1;
    else if (wr) it.br = 1;
    else if (sz == 2'b10) begin
      it.d = v; it.ds = vs; it.br = !(a == 8'h00 || a == 8'h10);
    end else if (!a[1]) begin
      it.d = {16'h0, v[15:0]}; it.ds = {16'h0, vs[15:0]};
      it.br = !(a == 8'h00 || a == 8'h10);
      m_hold = v[31:16]; m_hold_s = vs[31:16];
    end else begin
      it.d = {16'h0, m_hold}; it.ds = {16'h0, m_hold_s};
    end
    q.push_back(it);
    @(posedge clk);
    if (tk) m_cnt = m_cnt + 1;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 0; wr_en = 0; tick_en = 1;
      @(posedge clk);
      m_cnt = m_cnt + 1;
    end
    @(negedge clk);
    tick_en = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        check(rd_valid == it.v && rd_valid_s == it.v, it.req, "rd_valid", {31'h0, rd_valid}, {31'h0, it.v});
        if (it.v) begin
          check(rd_data == it.d, it.req, "rd_data", rd_data, it.d);
          check(rd_data_s == it.ds, it.req, "rd_data narrow", rd_data_s, it.ds);
        end
        check(err_reg == it.br && err_reg_s == it.br, it.req, "err_reg", {31'h0, err_reg}, {31'h0, it.br});
        check(err_width == it.bw && err_width_s == it.bw, it.req, "err_width", {31'h0, err_width}, {31'h0, it.bw});
      end else if (rd_valid || err_reg || err_width) begin
        check(0, "R1", "unexpected output", {29'h0, rd_valid, err_reg, err_width}, 32'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "R1", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rd_valid == 0 && err_reg == 0 && err_width == 0, "R1", "flags in reset",
          {29'h0, rd_valid, err_reg, err_width}, 32'h0);
    check(rd_data == 0 && rd_data_s == 0, "R1", "rd_data in reset", rd_data, 32'h0);
    rst_n = 1;
    access(1, 0, 2'b01, 8'h02, 0, "R7");
    access(1, 0, 2'b10, 8'h10, 0, "R1");
    idle_ticks(5);
    access(1, 0, 2'b10, 8'h10, 0, "R3");
    access(1, 0, 2'b10, 8'h10, 1, "R3");
    access(1, 0, 2'b10, 8'h10, 0, "R3");
    access(1, 0, 2'b10, 8'h00, 0, "R2");
    access(1, 0, 2'b01, 8'h00, 0, "R5");
    access(1, 0, 2'b01, 8'h12, 0, "R5");
    idle_ticks(32'hFFF0 - m_cnt);
    access(1, 0, 2'b01, 8'h10, 0, "R5");
    idle_ticks(32'h20);
    access(1, 0, 2'b01, 8'h12, 0, "R6");
    access(1, 0, 2'b01, 8'h10, 0, "R5");
    access(1, 0, 2'b01, 8'h02, 0, "R6");
    access(1, 0, 2'b10, 8'h10, 0, "R4");
    access(1, 0, 2'b00, 8'h10, 0, "R10");
    access(1, 0, 2'b01, 8'h12, 0, "R10");
    access(1, 0, 2'b11, 8'h10, 0, "R10");
    access(0, 1, 2'b10, 8'h10, 0, "R9");
    access(0, 1, 2'b01, 8'h10, 0, "R9");
    access(0, 1, 2'b00, 8'h00, 0, "R10");
    access(1, 0, 2'b10, 8'h10, 0, "R9");
    access(1, 0, 2'b01, 8'h16, 0, "R9");
    access(1, 0, 2'b10, 8'h04, 0, "R8");
    access(1, 0, 2'b01, 8'h08, 0, "R8");
    access(1, 0, 2'b01, 8'h0A, 0, "R8");
    idle_ticks(300);
    access(1, 0, 2'b10, 8'h10, 1, "R4");
    access(1, 0, 2'b10, 8'h10, 0, "R4");
    @(negedge clk);
    rd_en = 0; wr_en = 0; tick_en = 0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "pending results", q.size(), 32'h0);
    finish_run();
  end
endmodule